// File: doc/BRIEF.md
# I2C Register File Target

This block lets an external two-wire bus master read and write a 256-entry, byte-wide register file. It takes already-synchronized SCL and SDA levels and drives SDA open-drain: when `sda_oe` is high the pad pulls the line low, and otherwise the line floats. The block recognises START and STOP conditions and answers one fixed 7-bit device address. The first byte of a write transaction loads an 8-bit register pointer. Every byte transferred after that, in either direction, moves the pointer up by one, wrapping from 0xFF to 0x00.

A read works in two steps. The master first writes only the pointer byte and ends with STOP (or a repeated START). A later transaction with the direction bit set then returns bytes starting at that pointer. The pointer keeps its value between transactions. If the line stays low for a parameterized number of system clocks, the bus engine releases SDA and goes idle, so a master that resets part-way through a read cannot leave the bus stuck.

Local logic uses a plain parallel port on the same storage: a combinational read and a single-cycle write strobe. This port has no handshake and never applies back-pressure. If both sides write the same entry in the same cycle, the bus write wins.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset `sda_oe` is 0 and every register reads 0x00 on the local port.
- R2: When the address byte's upper 7 bits equal `DEV_ADDR`, the target pulls SDA low for the whole ninth SCL high phase. The byte is sent MSB first and its bit 0 is the direction: 1 means read, 0 means write.
- R3: For a non-matching address the target acknowledges neither the address nor any later byte, does not drive data, and changes no register until the next START or STOP.
- R4: In a write transaction the first byte after the address sets the pointer, and each later byte is stored at the pointer. Every one of these bytes is acknowledged.
- R5: Each stored byte advances the pointer by one, and the pointer wraps from 0xFF to 0x00.
- R6: A read transaction sends the register at the pointer MSB first. The pointer keeps its value across STOP, so a pointer set in one transaction serves a later read.
- R7: In a read, an acknowledge from the master (SDA low on the ninth clock) makes the target send the next register. A not-acknowledge leaves SDA released until the next START.
- R8: A START in the middle of a transaction abandons the partial byte without storing it and restarts address matching.
- R9: If SDA stays low for `TIMEOUT_CYC` consecutive clocks, the target releases SDA and returns to idle. A new START then works normally.
- R10: `loc_rdata` shows the register at `loc_addr` combinationally. A `loc_we` pulse stores `loc_wdata` there at the next clock edge, and the bus sees the new value.
- R11: After STOP the target releases SDA and ignores bytes clocked in without a fresh START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (wired line) |
| sda_oe | output | 1 | 1 pulls SDA low |
| loc_addr | input | 8 | Local port register index |
| loc_we | input | 1 | Local write strobe |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Register contents at `loc_addr` |

## Verification
A wrong protocol state shows at the ports within one SCL bit. An acknowledge appears in the wrong ninth clock, a data bit is driven while the master owns the line, or SDA is held after a not-acknowledge. A pointer error does not show on the bus until the next read byte, but the local port reveals it at the clock edge that stores the misplaced byte. The bench therefore compares the local read port with its own model on every clock, as well as checking each acknowledge and each read bit on the bus.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACKP,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_TXACK,
    ST_SKIP
  } tgt_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic tmo;
  } bus_evt_t;

endpackage

// File: rtl/i2c_tgt_linemon.sv
module i2c_tgt_linemon
  import i2c_tgt_pkg::*;
#(
  parameter int TIMEOUT_CYC = 3_125_000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIM_M1 = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] LIM    = CW'(TIMEOUT_CYC);

  logic          scl_q, sda_q;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      low_cnt <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (sda_i)
        low_cnt <= '0;
      else if (low_cnt != LIM)
        low_cnt <= low_cnt + 1'b1;
    end
  end

  // START: SDA falls while SCL stays high; STOP: SDA rises while SCL stays high
  assign evt.start = scl_q & scl_i & sda_q & ~sda_i;
  assign evt.stop  = scl_q & scl_i & ~sda_q & sda_i;
  assign evt.rise  = ~scl_q & scl_i;
  assign evt.fall  = scl_q & ~scl_i;
  assign evt.tmo   = ~sda_i & (low_cnt == LIM_M1);

  // R9: the timeout pulse only follows a low run on SDA
  p_tmo_after_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt.tmo |-> !sda_i && $past(!sda_i));

endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (loc_we) mem[loc_addr] <= loc_wdata;
      if (bus_we) mem[bus_addr] <= bus_wdata;  // later statement: bus wins a collision
    end
  end

  assign bus_rdata = mem[bus_addr];
  assign loc_rdata = mem[loc_addr];

  // R4: a bus write is visible at its address one cycle later
  p_bus_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> mem[$past(bus_addr)] == $past(bus_wdata));

  // R10: a local write without a colliding bus write lands
  p_loc_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_we && !(bus_we && bus_addr == loc_addr)) |=> mem[$past(loc_addr)] == $past(loc_wdata));

endmodule

// File: rtl/i2c_tgt_proto.sv
module i2c_tgt_proto
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h60,
  parameter int         AW       = 8,
  parameter int         DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_evt_t      evt,
  input  logic          sda_i,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          sda_oe
);
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST = BW'(DW - 1);

  tgt_state_e    state;
  logic [BW-1:0] bitn;
  logic [DW-1:0] rx_sh, tx_sh;
  logic          is_rd, first, mack;
  logic [DW-1:0] rx_byte;

  assign rx_byte = {rx_sh[DW-2:0], sda_i};
  assign wr_data = rx_byte;
  assign wr_en   = (state == ST_RX) && evt.rise && (bitn == LAST) && !first
                   && !evt.start && !evt.stop && !evt.tmo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitn   <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      is_rd  <= 1'b0;
      first  <= 1'b0;
      mack   <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (evt.tmo || evt.stop) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (evt.start) begin
      state  <= ST_ADDR;
      bitn   <= '0;
      first  <= 1'b1;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (evt.rise) begin
          rx_sh <= rx_byte;
          bitn  <= bitn + 1'b1;
          if (bitn == LAST) begin
            if (rx_sh[6:0] == DEV_ADDR) begin
              is_rd <= sda_i;
              state <= ST_ACKP;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_RX: if (evt.rise) begin
          rx_sh <= rx_byte;
          bitn  <= bitn + 1'b1;
          if (bitn == LAST) begin
            state <= ST_ACKP;
            if (first) begin
              ptr   <= AW'(rx_byte);
              first <= 1'b0;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end
        end
        ST_ACKP: if (evt.fall) begin
          sda_oe <= 1'b1;
          state  <= ST_ACK;
        end
        ST_ACK: if (evt.fall) begin
          bitn <= '0;
          if (is_rd) begin
            tx_sh  <= rd_data;
            sda_oe <= ~rd_data[DW-1];
            state  <= ST_TX;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_RX;
          end
        end
        ST_TX: if (evt.fall) begin
          if (bitn == LAST) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
            state  <= ST_TXACK;
          end else begin
            tx_sh  <= {tx_sh[DW-2:0], 1'b0};
            sda_oe <= ~tx_sh[DW-2];
            bitn   <= bitn + 1'b1;
          end
        end
        ST_TXACK: begin
          if (evt.rise) mack <= ~sda_i;
          if (evt.fall) begin
            if (mack) begin
              bitn   <= '0;
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              state  <= ST_TX;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;  // ST_IDLE, ST_SKIP wait for START
      endcase
    end
  end

  // R9: a timeout leaves the line released
  p_tmo_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt.tmo |=> !sda_oe && state == ST_IDLE);

  // R11: STOP releases the line
  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stop |=> !sda_oe);

  // R3 / R7: no drive while ignoring the bus
  p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SKIP |-> !sda_oe);

  // R2: the line is only pulled after a falling SCL edge
  p_oe_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(evt.fall));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h60,
  parameter int         TIMEOUT_CYC = 3_125_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [7:0] loc_addr,
  input  logic       loc_we,
  input  logic [7:0] loc_wdata,
  output logic [7:0] loc_rdata
);
  localparam int AW = 8;
  localparam int DW = 8;

  bus_evt_t      evt;
  logic [AW-1:0] ptr;
  logic          wr_en;
  logic [DW-1:0] wr_data, rd_data;

  i2c_tgt_linemon #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt   (evt)
  );

  i2c_tgt_proto #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) u_proto (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .sda_i   (sda_i),
    .rd_data (rd_data),
    .ptr     (ptr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sda_oe  (sda_oe)
  );

  i2c_tgt_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (wr_en),
    .bus_addr  (ptr),
    .bus_wdata (wr_data),
    .bus_rdata (rd_data),
    .loc_we    (loc_we),
    .loc_addr  (loc_addr),
    .loc_wdata (loc_wdata),
    .loc_rdata (loc_rdata)
  );

endmodule

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;
  localparam int         TO   = 400;
  localparam logic [6:0] DEV  = 7'h60;
  localparam int         HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda_m = 1'b1;
  logic       sda_line, sda_oe;
  logic [7:0] loc_addr, loc_wdata = 8'h00, loc_rdata, scan = 8'h00, lw_addr = 8'h00;
  logic       loc_we = 1'b0, lw_mode = 1'b0, mon_on = 1'b0;
  logic [7:0] exp_mem [256];
  int         errors = 0, checks = 0, quiet = 0, cyc = 0;

  assign sda_line = sda_m & ~sda_oe;
  assign loc_addr = lw_mode ? lw_addr : scan;

  i2c_reg_target #(.DEV_ADDR(DEV), .TIMEOUT_CYC(TO)) u_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .loc_addr(loc_addr), .loc_we(loc_we), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock model comparison of the local read port (R10)
  always @(posedge clk) scan <= scan + 8'd1;
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (quiet > 0) quiet--;
      else check(loc_rdata == exp_mem[loc_addr], "R10 model compare", loc_rdata, exp_mem[loc_addr]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic bstart();
    sda_m = 1; idle(HALF); scl = 1; idle(HALF); sda_m = 0; idle(HALF); scl = 0; idle(HALF);
  endtask

  task automatic bstop();
    sda_m = 0; idle(HALF); scl = 1; idle(HALF); sda_m = 1; idle(HALF);
  endtask

  task automatic send_byte(logic [7:0] b, bit exp_ack, string tag, bit store, logic [7:0] at);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; idle(HALF); scl = 1;
      if (i == 0 && store) begin exp_mem[at] = b; quiet = 3; end
      idle(HALF); scl = 0; idle(2);
    end
    sda_m = 1; idle(HALF); scl = 1; idle(2);
    check(sda_oe == exp_ack, tag, sda_oe, exp_ack);
    idle(HALF - 2); scl = 0; idle(2);
  endtask

  task automatic read_byte(bit mack, output logic [7:0] v);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      idle(HALF); scl = 1; idle(2); v[i] = sda_line; idle(HALF - 2); scl = 0; idle(2);
    end
    sda_m = mack ? 1'b0 : 1'b1; idle(HALF); scl = 1; idle(HALF); scl = 0; idle(2); sda_m = 1;
  endtask

  task automatic loc_write(logic [7:0] a, logic [7:0] d);
    lw_mode = 1; lw_addr = a; loc_wdata = d; loc_we = 1; quiet = 3;
    idle(1); loc_we = 0; exp_mem[a] = d; idle(1); lw_mode = 0;
  endtask

  task automatic loc_check(logic [7:0] a, logic [7:0] e, string tag);
    lw_mode = 1; lw_addr = a; quiet = 2; idle(1);
    check(loc_rdata == e, tag, loc_rdata, e);
    lw_mode = 0;
  endtask

  task automatic set_ptr(logic [7:0] p);
    bstart();
    send_byte({DEV, 1'b0}, 1, "R2 address ack", 0, 0);
    send_byte(p, 1, "R4 pointer ack", 0, 0);
    bstop();
  endtask

  task automatic read_run(int n, logic [7:0] p0, string tag);
    logic [7:0] v;
    bstart();
    send_byte({DEV, 1'b1}, 1, "R6 read address ack", 0, 0);
    for (int k = 0; k < n; k++) begin
      read_byte(k < n - 1, v);
      check(v == exp_mem[8'(p0 + k)], tag, v, exp_mem[8'(p0 + k)]);
    end
    check(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    bstop();
  endtask

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    idle(10);
    check(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1; idle(2);
    check(loc_rdata == 8'h00, "R1 register after reset", loc_rdata, 0);
    mon_on = 1;

    // R10 local writes
    loc_write(8'h40, 8'h5A);
    loc_write(8'h01, 8'hC3);
    loc_check(8'h40, 8'h5A, "R10 local write");

    // R4/R5 burst write wrapping 0xFE..0x00
    bstart();
    send_byte({DEV, 1'b0}, 1, "R2 address ack", 0, 0);
    send_byte(8'hFE, 1, "R4 pointer ack", 0, 0);
    send_byte(8'h11, 1, "R4 data ack", 1, 8'hFE);
    send_byte(8'h22, 1, "R5 data ack", 1, 8'hFF);
    send_byte(8'h33, 1, "R5 wrap data ack", 1, 8'h00);
    bstop();
    check(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);
    loc_check(8'h00, 8'h33, "R5 wrap to 0x00");
    loc_check(8'hFF, 8'h22, "R5 increment");

    // R6 two-stage read, then R7 burst continuing from held pointer
    set_ptr(8'hFE);
    read_run(1, 8'hFE, "R6 single read");
    read_run(3, 8'hFF, "R7 burst read from held pointer");

    // R4 single write
    bstart();
    send_byte({DEV, 1'b0}, 1, "R2 address ack", 0, 0);
    send_byte(8'h80, 1, "R4 pointer ack", 0, 0);
    send_byte(8'hA5, 1, "R4 single data ack", 1, 8'h80);
    bstop();

    // R3 non-matching addresses
    bstart();
    send_byte({7'h50, 1'b0}, 0, "R3 no ack wrong address", 0, 0);
    send_byte(8'h80, 0, "R3 no ack pointer", 0, 0);
    send_byte(8'h3C, 0, "R3 no ack data", 0, 0);
    bstop();
    loc_check(8'h80, 8'hA5, "R3 register untouched");
    bstart();
    send_byte({7'h61, 1'b1}, 0, "R3 no ack read address", 0, 0);
    read_byte(0, v);
    check(v == 8'hFF, "R3 no data driven", v, 8'hFF);
    bstop();

    // R8 repeated start aborts a partial byte
    bstart();
    send_byte({DEV, 1'b0}, 1, "R2 address ack", 0, 0);
    send_byte(8'h40, 1, "R4 pointer ack", 0, 0);
    for (int i = 0; i < 3; i++) begin
      sda_m = 0; idle(HALF); scl = 1; idle(HALF); scl = 0; idle(2);
    end
    bstart();
    send_byte({DEV, 1'b1}, 1, "R8 address ack after restart", 0, 0);
    read_byte(0, v);
    check(v == 8'h5A, "R8 read after restart", v, 8'h5A);
    bstop();
    loc_check(8'h40, 8'h5A, "R8 partial byte not stored");

    // R9 SDA stuck low while the target drives a zero bit
    set_ptr(8'h90);
    bstart();
    send_byte({DEV, 1'b1}, 1, "R6 read address ack", 0, 0);
    idle(100);
    check(sda_oe == 1'b1, "R9 held before timeout", sda_oe, 1);
    idle(TO);
    check(sda_oe == 1'b0, "R9 released by timeout", sda_oe, 0);
    sda_m = 1; idle(HALF); scl = 1; idle(HALF);
    set_ptr(8'h40);
    read_run(1, 8'h40, "R9 recovery read");

    // R11 bytes without START are ignored
    sda_m = 1; idle(HALF); scl = 0; idle(2);
    send_byte({DEV, 1'b0}, 0, "R11 no ack without start", 0, 0);
    scl = 1; idle(HALF);

    idle(20);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule